// File: doc/BRIEF.md
# Z80 Bank-Switching Memory Pager

This block sits between an 8-bit Z80-style CPU bus and a pair of 512 KiB memories, one flash ROM and one RAM. It splits the 64 KiB logical space into two 32 KiB windows. The lower window (logical 0x0000 to 0x7FFF) can be pointed at any 32 KiB page of either device. The upper window (logical 0x8000 to 0xFFFF) is tied permanently to the highest 32 KiB page of RAM. The lower window is chosen by a write-only bank register that answers at I/O ports 0x78 and 0x79.

The block drives the five extended physical address lines A19..A15 that sit above the CPU's A14..A0. It also drives the active-low chip enables for ROM and RAM and the shared output and write enables. A strap input tells the pager that only 128 KiB of RAM is fitted. In that case the two upper RAM page bits are held high, so that the upper window still reaches real memory and the lower RAM pages alias onto it. Bus strobes are sampled on the system clock `clk`. The bank register takes the new value when a qualified I/O write ends, so the new mapping applies from the next memory cycle.

Top module: `z80_mem_pager`

## Requirements
- R1: After reset the bank register holds 0. A memory cycle with A15 = 0 then drives ext_addr = 5'b00000 and asserts rom_ce_n, so the CPU starts from the first 32 KiB of flash.
- R2: I/O writes to port 0x78 and to port 0x79 load the same register. A write to any other port low byte (for example 0x7A) leaves the mapping unchanged.
- R3: A qualified write needs iorq_n = 0, wr_n = 0 and m1_n = 1, and address bits 15:8 play no part in it. A cycle with m1_n = 0, or a memory write, never changes the mapping.
- R4: Only data bits 5:1 are stored. Bit 5 is the device bit (0 = flash, 1 = RAM) and bits 4:1 are the page within the device. Data bits 0, 6 and 7 have no effect.
- R5: The register does not change while the qualified write is active. At the first clock edge where the strobe is seen inactive, it takes the data bits sampled during the last active cycle.
- R6: With A15 = 1 the output is ext_addr = 5'b11111 whatever the register holds, and RAM is the device selected.
- R7: With A15 = 0 the output is ext_addr = {device bit, page[3:0]}, where ext_addr[4] drives physical A19 and ext_addr[3:0] drive A18..A15.
- R8: rom_ce_n is low only for mreq_n = 0, rfsh_n = 1, A15 = 0 and device bit 0. ram_ce_n is low for every other cycle with mreq_n = 0 and rfsh_n = 1. Both enables stay high during refresh.
- R9: With ram_small = 1, any access that targets RAM drives ext_addr[3:2] = 2'b11. Flash accesses keep their page unchanged.
- R10: mem_oe_n is low exactly when mreq_n = 0 and rd_n = 0. mem_we_n is low exactly when mreq_n = 0 and wr_n = 0. Both ignore the device selected, so flash can be written in system.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Logical CPU address |
| cpu_data | input | 8 | CPU data bus (write data for the bank register) |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch / interrupt-acknowledge marker, active low |
| rfsh_n | input | 1 | Refresh cycle marker, active low |
| ram_small | input | 1 | Strap: 1 = 128 KiB RAM fitted, 0 = 512 KiB |
| ext_addr | output | 5 | Physical address lines A19..A15 |
| rom_ce_n | output | 1 | Flash chip enable, active low |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |

## Verification
The bench builds the pager with its default parameters: an 8-bit port decode with one ignored low bit, a 5-bit field at data bits 5:1, 16 pages per device and a 2-bit page range for the small strap. These defaults make the real ports 0x78/0x79 and the 128 KiB aliasing reachable with only a few bus cycles. With them the bench can drive every device/page combination that the register field encodes, toggle the strap in both directions and check the stored value against each data-bit position. A behavioural model tracks the register through the strobe's end and is compared with all five outputs on every clock.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

   typedef enum logic {
      DEV_FLASH = 1'b0,
      DEV_RAM   = 1'b1
   } pgr_dev_e;

   // Qualified CPU I/O write: request, write strobe, and not an interrupt acknowledge.
   function automatic logic io_write_qual(input logic iorq_n, input logic wr_n, input logic m1_n);
      return !iorq_n && !wr_n && m1_n;
   endfunction

endpackage

// File: rtl/pgr_io_decode.sv
module pgr_io_decode #(
   parameter int          LOG_AW      = 16,
   parameter int          PORT_W      = 8,
   parameter logic [15:0] PORT_BASE   = 16'h0078,
   parameter int          IGN_LSBS    = 1,
   parameter bit          DECODE_HIGH = 1'b0
) (
   input  logic [LOG_AW-1:0] addr,
   input  logic              iorq_n,
   input  logic              wr_n,
   input  logic              m1_n,
   output logic              sel
);
   import pgr_pkg::*;

   localparam int CMP_TOP = DECODE_HIGH ? LOG_AW - 1 : PORT_W - 1;

   if (IGN_LSBS < 0 || IGN_LSBS >= PORT_W) begin : g_bad_ign
      $error("pgr_io_decode: IGN_LSBS out of range");
   end
   if (PORT_W > LOG_AW) begin : g_bad_pw
      $error("pgr_io_decode: PORT_W wider than address");
   end

   logic hit;

   if (DECODE_HIGH) begin : g_full
      assign hit = (addr[CMP_TOP:IGN_LSBS] == PORT_BASE[CMP_TOP:IGN_LSBS]);
   end else begin : g_low
      assign hit = (addr[CMP_TOP:IGN_LSBS] == PORT_BASE[CMP_TOP:IGN_LSBS]);
      if (LOG_AW > PORT_W) begin : g_spare
         logic unused_high;
         assign unused_high = ^addr[LOG_AW-1:PORT_W];
      end
   end

   if (IGN_LSBS > 0) begin : g_lsb_spare
      logic unused_lsbs;
      assign unused_lsbs = ^addr[IGN_LSBS-1:0];
   end

   assign sel = io_write_qual(iorq_n, wr_n, m1_n) && hit;

endmodule

// File: rtl/pgr_bank_reg.sv
module pgr_bank_reg #(
   parameter int DATA_W    = 8,
   parameter int FIELD_LSB = 1,
   parameter int FIELD_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               strobe,
   input  logic [DATA_W-1:0]  data,
   output logic [FIELD_W-1:0] field
);
   localparam int FIELD_MSB = FIELD_LSB + FIELD_W - 1;

   if (FIELD_MSB >= DATA_W) begin : g_bad_field
      $error("pgr_bank_reg: field does not fit the data bus");
   end

   logic               strobe_q;
   logic [FIELD_W-1:0] hold_q;
   logic               commit;

   assign commit = strobe_q && !strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         hold_q   <= '0;
         field    <= '0;
      end else begin
         strobe_q <= strobe;
         if (strobe) hold_q <= data[FIELD_MSB:FIELD_LSB];
         if (commit) field  <= hold_q;
      end
   end

   if (FIELD_LSB > 0) begin : g_low_spare
      logic unused_low;
      assign unused_low = ^data[FIELD_LSB-1:0];
   end
   if (FIELD_MSB < DATA_W - 1) begin : g_high_spare
      logic unused_high;
      assign unused_high = ^data[DATA_W-1:FIELD_MSB+1];
   end

   // R5: no update while the write strobe is still active
   a_r5_hold_during_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> $stable(field));

   // R5: a strobe that ends loads the data sampled in its last cycle
   a_r5_commit_value: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !$past(!rst_n)) ##1 !strobe |=> field == $past(data[FIELD_MSB:FIELD_LSB], 2));

endmodule

// File: rtl/pgr_addr_map.sv
module pgr_addr_map #(
   parameter int PAGE_W       = 4,
   parameter int SMALL_PAGE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PAGE_W:0]   field,
   input  logic              a_top,
   input  logic              mreq_n,
   input  logic              rfsh_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              ram_small,
   output logic [PAGE_W:0]   ext_addr,
   output logic              rom_ce_n,
   output logic              ram_ce_n,
   output logic              oe_n,
   output logic              we_n
);
   import pgr_pkg::*;

   if (SMALL_PAGE_W > PAGE_W || SMALL_PAGE_W < 0) begin : g_bad_small
      $error("pgr_addr_map: SMALL_PAGE_W out of range");
   end

   pgr_dev_e          dev;
   logic [PAGE_W-1:0] raw_page;
   logic [PAGE_W-1:0] eff_page;
   logic              mem_live;

   always_comb begin
      if (a_top) begin
         dev      = DEV_RAM;
         raw_page = '1;
      end else begin
         dev      = pgr_dev_e'(field[PAGE_W]);
         raw_page = field[PAGE_W-1:0];
      end
   end

   for (genvar i = 0; i < PAGE_W; i++) begin : g_page_bit
      if (i >= SMALL_PAGE_W) begin : g_strapped
         assign eff_page[i] = raw_page[i] | (ram_small && dev == DEV_RAM);
      end else begin : g_free
         assign eff_page[i] = raw_page[i];
      end
   end

   assign mem_live = !mreq_n && rfsh_n;
   assign ext_addr = {dev == DEV_RAM, eff_page};
   assign rom_ce_n = !(mem_live && dev == DEV_FLASH);
   assign ram_ce_n = !(mem_live && dev == DEV_RAM);
   assign oe_n     = !(!mreq_n && !rd_n);
   assign we_n     = !(!mreq_n && !wr_n);

   // R8: refresh never selects a device
   a_r8_quiet_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
      !rfsh_n |-> (rom_ce_n && ram_ce_n));

   // R8: at most one device enabled
   a_r8_one_device: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rom_ce_n && !ram_ce_n));

   // R9: small strap keeps RAM pages in the fitted range
   a_r9_small_alias: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_small && !ram_ce_n) |-> (ext_addr[PAGE_W-1:SMALL_PAGE_W] == '1));

   // R10: write enable follows the memory write whatever the device
   a_r10_we_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (!mreq_n && !wr_n) |-> !we_n);

endmodule

// File: rtl/z80_mem_pager.sv
module z80_mem_pager #(
   parameter int          LOG_AW       = 16,
   parameter int          DATA_W       = 8,
   parameter int          PORT_W       = 8,
   parameter logic [15:0] PORT_BASE    = 16'h0078,
   parameter int          IGN_LSBS     = 1,
   parameter bit          DECODE_HIGH  = 1'b0,
   parameter int          FIELD_LSB    = 1,
   parameter int          PAGE_W       = 4,
   parameter int          SMALL_PAGE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LOG_AW-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              mreq_n,
   input  logic              iorq_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              m1_n,
   input  logic              rfsh_n,
   input  logic              ram_small,
   output logic [PAGE_W:0]   ext_addr,
   output logic              rom_ce_n,
   output logic              ram_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n
);
   localparam int FIELD_W = PAGE_W + 1;

   if (LOG_AW < 2) begin : g_bad_aw
      $error("z80_mem_pager: LOG_AW too small");
   end

   logic               io_sel;
   logic [FIELD_W-1:0] bank;

   pgr_io_decode #(
      .LOG_AW      (LOG_AW),
      .PORT_W      (PORT_W),
      .PORT_BASE   (PORT_BASE),
      .IGN_LSBS    (IGN_LSBS),
      .DECODE_HIGH (DECODE_HIGH)
   ) u_dec (
      .addr   (cpu_addr),
      .iorq_n (iorq_n),
      .wr_n   (wr_n),
      .m1_n   (m1_n),
      .sel    (io_sel)
   );

   pgr_bank_reg #(
      .DATA_W    (DATA_W),
      .FIELD_LSB (FIELD_LSB),
      .FIELD_W   (FIELD_W)
   ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (io_sel),
      .data   (cpu_data),
      .field  (bank)
   );

   pgr_addr_map #(
      .PAGE_W       (PAGE_W),
      .SMALL_PAGE_W (SMALL_PAGE_W)
   ) u_map (
      .clk       (clk),
      .rst_n     (rst_n),
      .field     (bank),
      .a_top     (cpu_addr[LOG_AW-1]),
      .mreq_n    (mreq_n),
      .rfsh_n    (rfsh_n),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .ram_small (ram_small),
      .ext_addr  (ext_addr),
      .rom_ce_n  (rom_ce_n),
      .ram_ce_n  (ram_ce_n),
      .oe_n      (mem_oe_n),
      .we_n      (mem_we_n)
   );

   // R3: interrupt-acknowledge style cycles never move the mapping
   a_r3_m1_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      !m1_n |=> $stable(bank));

   // R6: upper half always lands on the top RAM page
   a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (!mreq_n && rfsh_n && cpu_addr[LOG_AW-1]) |-> (!ram_ce_n && ext_addr == '1));

endmodule

// File: tb/tb_z80_mem_pager.sv
`timescale 1ns/1ps
module tb_z80_mem_pager;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic [7:0]  cpu_data = 8'h00;
   logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic        m1_n = 1'b1, rfsh_n = 1'b1, ram_small = 1'b0;
   logic [4:0]  ext_addr;
   logic        rom_ce_n, ram_ce_n, mem_oe_n, mem_we_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   z80_mem_pager dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
      .m1_n(m1_n), .rfsh_n(rfsh_n), .ram_small(ram_small),
      .ext_addr(ext_addr), .rom_ce_n(rom_ce_n), .ram_ce_n(ram_ce_n),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
   );

   // behavioural reference model
   int m_page = 0, m_hold = 0;
   bit m_prev = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_page = 0; m_hold = 0; m_prev = 0;
      end else begin
         bit cur;
         cur = !iorq_n && !wr_n && m1_n && (cpu_addr[7:0] == 8'h78 || cpu_addr[7:0] == 8'h79);
         if (m_prev && !cur) m_page = m_hold;
         if (cur) m_hold = (cpu_data >> 1) & 31;
         m_prev = cur;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit ram_t; int pg; bit live;
         ram_t = cpu_addr[15] ? 1'b1 : m_page[4];
         pg    = cpu_addr[15] ? 15 : (m_page & 15);
         if (ram_t && ram_small) pg = pg | 12;
         live  = !mreq_n && rfsh_n;
         chk(cpu_addr[15] ? "R6 model ext_addr" : (ram_t && ram_small) ? "R9 model ext_addr" : "R7 model ext_addr",
             ext_addr, {ram_t, pg[3:0]});
         chk("R8 model rom_ce_n", rom_ce_n, !(live && !ram_t));
         chk("R8 model ram_ce_n", ram_ce_n, !(live && ram_t));
         chk("R10 model mem_oe_n", mem_oe_n, !(!mreq_n && !rd_n));
         chk("R10 model mem_we_n", mem_we_n, !(!mreq_n && !wr_n));
      end
   end

   task automatic idle();
      cpu_addr = 16'h0000; mreq_n = 1; iorq_n = 1; rd_n = 1; wr_n = 1; m1_n = 1; rfsh_n = 1;
   endtask

   task automatic io_wr(input logic [15:0] port, input logic [7:0] d, input logic m1);
      @(posedge clk); #1;
      cpu_addr = port; cpu_data = d; iorq_n = 0; wr_n = 0; m1_n = m1;
      @(posedge clk); @(posedge clk); #1;
      idle();
      @(posedge clk); #1;
   endtask

   // memory cycle; returns outputs sampled at the following negedge
   task automatic mem(input logic a15, input logic wr, input logic refresh,
                      output logic [4:0] ea, output logic rce, output logic ace, output logic we);
      @(posedge clk); #1;
      cpu_addr = {a15, 15'h1234}; mreq_n = 0; rd_n = wr; wr_n = !wr; rfsh_n = !refresh;
      @(negedge clk);
      ea = ext_addr; rce = rom_ce_n; ace = ram_ce_n; we = mem_we_n;
      @(posedge clk); #1;
      idle();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [4:0] ea; logic rce, ace, we;
      idle();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1: reset state maps flash page 0
      mem(0, 0, 0, ea, rce, ace, we);
      chk("R1 ext_addr after reset", ea, 5'b00000);
      chk("R1 rom_ce_n after reset", rce, 0);

      // R2/R7: port 0x78, data 0x22 -> RAM page 1
      io_wr(16'h0078, 8'h22, 1);
      mem(0, 0, 0, ea, rce, ace, we);
      chk("R2 port 0x78 load", ea, 5'b10001);
      chk("R7 RAM lower window ce", ace, 0);

      // R2/R4: port 0x79, data 0x0B -> flash page 5, bit0 ignored
      io_wr(16'h0079, 8'h0B, 1);
      mem(0, 0, 0, ea, rce, ace, we);
      chk("R2 port 0x79 load", ea, 5'b00101);
      chk("R7 flash lower window ce", rce, 0);

      // R4: bits 7:6 and 0 ignored, 0xC7 -> 00011
      io_wr(16'h0078, 8'hC7, 1);
      mem(0, 0, 0, ea, rce, ace, we);
      chk("R4 upper/lsb data bits ignored", ea, 5'b00011);

      // R2: other port ignored
      io_wr(16'h007A, 8'h3E, 1);
      mem(0, 0, 0, ea, rce, ace, we);
      chk("R2 port 0x7A ignored", ea, 5'b00011);

      // R3: high address byte ignored
      io_wr(16'h3478, 8'h14, 1);
      mem(0, 0, 0, ea, rce, ace, we);
      chk("R3 high byte ignored", ea, 5'b01010);

      // R3: M1 low blocks
      io_wr(16'h0078, 8'h3E, 0);
      mem(0, 0, 0, ea, rce, ace, we);
      chk("R3 m1 blocks write", ea, 5'b01010);

      // R3: memory write to 0x0078 does not touch register
      @(posedge clk); #1;
      cpu_addr = 16'h0078; cpu_data = 8'h3E; mreq_n = 0; wr_n = 0;
      @(posedge clk); @(posedge clk); #1; idle();
      mem(0, 0, 0, ea, rce, ace, we);
      chk("R3 memory write ignored", ea, 5'b01010);

      // R5: no change while strobe active, change after it ends
      @(posedge clk); #1;
      cpu_addr = 16'h0078; cpu_data = 8'h22; iorq_n = 0; wr_n = 0;
      @(posedge clk); @(negedge clk);
      chk("R5 held during strobe", ext_addr, 5'b01010);
      @(posedge clk); #1;
      cpu_data = 8'h24;                      // last strobe cycle carries new data
      @(negedge clk);
      chk("R5 held in last strobe cycle", ext_addr, 5'b01010);
      @(posedge clk); #1; idle();
      @(negedge clk);
      chk("R5 still old before commit edge", ext_addr, 5'b01010);
      @(posedge clk); @(negedge clk);
      chk("R5 last-cycle data committed", ext_addr, 5'b10010);

      // R6: upper window
      mem(1, 0, 0, ea, rce, ace, we);
      chk("R6 upper ext_addr", ea, 5'b11111);
      chk("R6 upper ram_ce_n", ace, 0);

      // R8: refresh cycle quiet
      mem(0, 0, 1, ea, rce, ace, we);
      chk("R8 refresh rom_ce_n", rce, 1);
      chk("R8 refresh ram_ce_n", ace, 1);

      // R9: small strap, RAM page 1 -> 11101, upper still 11111, flash unaffected
      io_wr(16'h0078, 8'h22, 1);
      ram_small = 1;
      mem(0, 0, 0, ea, rce, ace, we);
      chk("R9 small strap RAM alias", ea, 5'b11101);
      mem(1, 0, 0, ea, rce, ace, we);
      chk("R9 small strap upper", ea, 5'b11111);
      io_wr(16'h0079, 8'h0A, 1);
      mem(0, 0, 0, ea, rce, ace, we);
      chk("R9 small strap flash untouched", ea, 5'b00101);

      // R10: write enable reaches flash
      mem(0, 1, 0, ea, rce, ace, we);
      chk("R10 flash write we_n", we, 0);
      chk("R10 flash write rom_ce_n", rce, 0);
      ram_small = 0;
      mem(1, 1, 0, ea, rce, ace, we);
      chk("R10 RAM write we_n", we, 0);

      repeat (2) @(posedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule